// File: doc/BRIEF.md
# Exception Return Status Unstacker

This block performs the status-register side of a return from an exception or from a non-maskable interrupt. On each return strobe it pops the saved mode bits out of the 32-bit status word: the upper two bits are kept as they are, and the low 28-bit field is shifted down by ten places. Bits 29:28 are dropped. Every bit that the shift leaves empty reads as zero.

The shifted status is then examined. If the restored state is user mode, the current stack pointer is saved as the kernel stack pointer, and the user stack pointer becomes the live stack pointer. A pending flag is raised when the old status had its restart flag clear. The NMI return variant also forces the NMI-enable flag. All results are registered on the clock edge that follows the strobe. They hold until the next strobe.

Top module: `exc_return_unstack`

## Requirements
- R1: After a strobe, stat_out bits 17:0 take stat_in bits 27:10. Stat_out bits 29:18 are zero, except where R5 or R6 sets a flag bit.
- R2: On a normal return (ret_nmi=0), stat_out bits 31:30 equal stat_in bits 31:30.
- R3: When the shifted status has the user flag (bit 6, taken from stat_in bit 16) set, sp_out takes usp_in and ksp_out takes sp_in.
- R4: When the shifted user flag is clear, sp_out takes sp_in and ksp_out keeps its previous value.
- R5: When the restart flag (stat_in bit 8, before the shift) is clear, the pending flag (stat_out bit 7) is set.
- R6: When the restart flag is set, the pending flag is the plain shifted value, which is stat_in bit 17.
- R7: An NMI return (ret_nmi=1) sets the NMI-enable flag (bit 30) and otherwise follows R1 to R5.
- R8: Outputs update on the rising edge after ret_go is high, and ret_done is high for exactly that cycle. With ret_go low, all outputs hold and ret_done is low.
- R9: While rst_n is low, stat_out, sp_out, ksp_out and ret_done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_go | input | 1 | Return strobe, one cycle |
| ret_nmi | input | 1 | 1 selects NMI return, 0 selects normal exception return |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| stat_out | output | 32 | Restored status word |
| sp_out | output | 32 | Stack pointer after the return |
| ksp_out | output | 32 | Saved kernel stack pointer |
| ret_done | output | 1 | High in the cycle after a strobe |

## Verification
The user-mode stack swap and the pending-flag set can happen on the same strobe. The NMI return can add the forced NMI-enable bit to that same strobe. The stimulus table includes status words with bit 16 set and bit 8 clear, under both return kinds, so all three effects land together. Each result is judged by comparing stat_out, sp_out and ksp_out against a bench model built from the requirements. Separate entries take the swap alone and the pending set alone, so that a fault in one effect cannot be hidden behind the other.

// File: rtl/exc_return_unstack.sv
module exc_return_unstack #(
  parameter int DW      = 32,
  parameter int KEEP_W  = 2,
  parameter int FIELD_W = 28,
  parameter int SHIFT   = 10,
  parameter int U_BIT   = 6,
  parameter int P_BIT   = 7,
  parameter int R_BIT   = 8,
  parameter int M_BIT   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_go,
  input  logic          ret_nmi,
  input  logic [DW-1:0] stat_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] usp_in,
  output logic [DW-1:0] stat_out,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] ksp_out,
  output logic          ret_done
);

  localparam logic [DW-1:0] KEEP_MASK  = {{KEEP_W{1'b1}}, {(DW-KEEP_W){1'b0}}};
  localparam logic [DW-1:0] FIELD_MASK = {{(DW-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};
  localparam logic [DW-1:0] P_MASK     = DW'(1) << P_BIT;
  localparam logic [DW-1:0] M_MASK     = DW'(1) << M_BIT;

  logic [DW-1:0] shifted;
  logic [DW-1:0] restored;
  logic          to_user;
  logic          restart_clr;

  assign shifted     = (stat_in & KEEP_MASK) | ((stat_in & FIELD_MASK) >> SHIFT);
  assign to_user     = shifted[U_BIT];
  assign restart_clr = ~stat_in[R_BIT];
  assign restored    = shifted | (restart_clr ? P_MASK : '0) | (ret_nmi ? M_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_out <= '0;
      sp_out   <= '0;
      ksp_out  <= '0;
      ret_done <= 1'b0;
    end else begin
      ret_done <= ret_go;
      if (ret_go) begin
        stat_out <= restored;
        if (to_user) begin
          sp_out  <= usp_in;
          ksp_out <= sp_in;
        end else begin
          sp_out  <= sp_in;
        end
      end
    end
  end

endmodule

// File: rtl/exc_return_unstack_chk.sv
module exc_return_unstack_chk #(
  parameter int DW      = 32,
  parameter int SHIFT   = 10,
  parameter int U_BIT   = 6,
  parameter int P_BIT   = 7,
  parameter int R_BIT   = 8,
  parameter int M_BIT   = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ret_go,
  input logic          ret_nmi,
  input logic [DW-1:0] stat_in,
  input logic [DW-1:0] sp_in,
  input logic [DW-1:0] usp_in,
  input logic [DW-1:0] stat_out,
  input logic [DW-1:0] sp_out,
  input logic [DW-1:0] ksp_out,
  input logic          ret_done
);

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> ret_done);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_go |=> (!ret_done && $stable(stat_out) && $stable(sp_out) && $stable(ksp_out)));

  a_r2_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && !ret_nmi) |=> stat_out[DW-1:DW-2] == $past(stat_in[DW-1:DW-2]));

  a_r7_nmi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && ret_nmi) |=> stat_out[M_BIT]);

  a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && !stat_in[R_BIT]) |=> stat_out[P_BIT]);

  a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && stat_in[U_BIT+SHIFT]) |=> (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

  a_r4_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && !stat_in[U_BIT+SHIFT]) |=> (sp_out == $past(sp_in) && $stable(ksp_out)));

  a_r1_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> stat_out[29:18] == 12'h000);

endmodule

bind exc_return_unstack exc_return_unstack_chk #(
  .DW(DW), .SHIFT(SHIFT), .U_BIT(U_BIT), .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_go(ret_go), .ret_nmi(ret_nmi),
  .stat_in(stat_in), .sp_in(sp_in), .usp_in(usp_in),
  .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out), .ret_done(ret_done)
);

// File: tb/exc_return_unstack_bench.sv
module exc_return_unstack_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_go = 1'b0;
  logic        ret_nmi = 1'b0;
  logic [31:0] stat_in = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] usp_in = '0;
  logic [31:0] stat_out, sp_out, ksp_out;
  logic        ret_done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_ksp = '0;

  always #2.5 clk = ~clk;

  exc_return_unstack u_exc_return_unstack (
    .clk(clk), .rst_n(rst_n), .ret_go(ret_go), .ret_nmi(ret_nmi),
    .stat_in(stat_in), .sp_in(sp_in), .usp_in(usp_in),
    .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out), .ret_done(ret_done)
  );

  // {nmi, status, sp, usp}
  localparam logic [96:0] VEC [10] = '{
    {1'b0, 32'h0000_0000, 32'h1000_0000, 32'h2000_0000},
    {1'b0, 32'hFFFF_FFFF, 32'h1000_0010, 32'h2000_0010},
    {1'b1, 32'h0001_0100, 32'h1000_0020, 32'h2000_0020},
    {1'b1, 32'h0001_0000, 32'h1000_0030, 32'h2000_0030},
    {1'b0, 32'h3000_0100, 32'h1000_0040, 32'h2000_0040},
    {1'b0, 32'h8002_0100, 32'h1000_0050, 32'h2000_0050},
    {1'b0, 32'h4000_0000, 32'h1000_0060, 32'h2000_0060},
    {1'b1, 32'h8000_0100, 32'h1000_0070, 32'h2000_0070},
    {1'b0, 32'h0001_0000, 32'h1000_0080, 32'h2000_0080},
    {1'b0, 32'h0ABC_D5FF, 32'h1000_0090, 32'h2000_0090}
  };

  function automatic logic [31:0] model_stat(input logic nmi, input logic [31:0] s);
    logic [31:0] n;
    n = {s[31:30], 12'h000, s[27:10]};
    if (!s[8]) n[7] = 1'b1;
    if (nmi)   n[30] = 1'b1;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic nmi, input logic [31:0] s, input logic [31:0] sp,
                        input logic [31:0] usp);
    logic [31:0] es;
    logic [31:0] esp;
    @(negedge clk);
    ret_go = 1'b1; ret_nmi = nmi; stat_in = s; sp_in = sp; usp_in = usp;
    es = model_stat(nmi, s);
    if (s[16]) begin esp = usp; exp_ksp = sp; end
    else esp = sp;
    @(posedge clk); #1;
    check("R1/R2/R5/R6/R7 status", stat_out, es);
    check(s[16] ? "R3 sp swap" : "R4 sp kept", sp_out, esp);
    check(s[16] ? "R3 ksp saved" : "R4 ksp held", ksp_out, exp_ksp);
    check("R8 done pulse", {31'b0, ret_done}, 32'd1);
    @(negedge clk);
    ret_go = 1'b0;
  endtask

  initial begin
    #20000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] hs, hp, hk;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset status", stat_out, 32'h0);
    check("R9 reset sp", sp_out, 32'h0);
    check("R9 reset ksp", ksp_out, 32'h0);
    check("R9 reset done", {31'b0, ret_done}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 10; i++)
      strobe(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

    // R8: inputs change without strobe, outputs hold
    hs = stat_out; hp = sp_out; hk = ksp_out;
    @(negedge clk);
    stat_in = 32'h0001_0000; sp_in = 32'hDEAD_0000; usp_in = 32'hBEEF_0000; ret_nmi = 1'b1;
    @(posedge clk); #1;
    check("R8 idle status hold", stat_out, hs);
    check("R8 idle sp hold", sp_out, hp);
    check("R8 idle ksp hold", ksp_out, hk);
    check("R8 idle done low", {31'b0, ret_done}, 32'd0);

    // R7 vs R2: same word, normal then NMI
    strobe(1'b0, 32'h0000_0100, 32'h3000_0000, 32'h4000_0000);
    check("R2 bit30 not forced", {31'b0, stat_out[30]}, 32'd0);
    strobe(1'b1, 32'h0000_0100, 32'h3000_0004, 32'h4000_0004);
    check("R7 bit30 forced", {31'b0, stat_out[30]}, 32'd1);

    // R9: reset mid-run clears
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check("R9 mid reset status", stat_out, 32'h0);
    check("R9 mid reset ksp", ksp_out, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule